// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a small on-chip scratchpad that is split into sixteen word-wide banks. A group of sixteen lanes presents one request together: each lane may carry a word address and, optionally, a write with data. The block sends each address to the bank that holds that word and finds where lanes collide in a bank. It then spreads the colliding accesses over as few clock cycles as the collisions allow. The scratchpad banks are register arrays inside the block.

Lanes that read or write exactly the same word are served as one access, so a single word reaches any number of lanes in one cycle. Lanes that hit different words of one bank must take turns. A request therefore lasts as many cycles as the busiest bank has distinct words to touch. Each lane's done flag rises in the cycle its word is served. A one-cycle strobe marks the end of the request and reports how many service cycles it used. A new request can start only once the block is idle again.

Top module: `sbank_arbiter`

## Requirements
- R1: A word address is split so that its low 4 bits select the bank and the remaining upper bits select the row inside that bank. When every valid lane maps to a different bank, the request finishes after one service cycle and `req_cycles` reads 1.
- R2: When all valid lanes name the same word, that word is delivered to all of them in one service cycle, and `req_cycles` reads 1.
- R3: `req_cycles` equals the largest number of distinct words that valid lanes name in any single bank. A stride-2 pattern gives 2, a stride-8 pattern gives 8, and a stride-16 pattern gives 16.
- R4: Inside a bank, distinct words are served one per cycle. They are ordered by the lowest lane that names each word, and all lanes naming that word are served together. `lane_done[i]` rises at the k-th clock edge after the accepting edge, where k is the service slot of lane i. It then stays high until the next request is accepted.
- R5: Read data returned to a lane is the content that word held when the request was accepted. A write to the same word in the same request does not change it.
- R6: When several lanes write the same word in one request, the word afterwards holds the data of the highest-numbered of those lanes.
- R7: `req_done` is high for exactly one cycle. It rises at the edge that ends the last service cycle, and `req_cycles` is valid from that edge on. A request with no valid lane completes one edge after acceptance with `req_cycles` = 0.
- R8: `ready` is high only while idle. A request is accepted at a clock edge where `req_go` and `ready` are both high, and `req_go` while `ready` is low has no effect on storage or outputs.
- R9: Lanes whose valid bit is low are never served. Their done flag stays low and they write nothing.
- R10: After reset, `ready` is 1 and `lane_done`, `req_done` and `req_cycles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_go | input | 1 | Start a request (taken when ready) |
| lane_valid | input | 16 | Per-lane request enable |
| lane_addr | input | 128 | Per-lane word address, 8 bits each, lane i at bits [8i+7:8i] |
| lane_we | input | 16 | Per-lane write enable |
| lane_wdata | input | 512 | Per-lane write data, 32 bits each, lane i at bits [32i+31:32i] |
| ready | output | 1 | Idle, a request can be accepted |
| lane_rdata | output | 512 | Per-lane read data, 32 bits each |
| lane_done | output | 16 | Per-lane served flag, sticky within a request |
| req_done | output | 1 | One-cycle request-complete strobe |
| req_cycles | output | 5 | Service cycles used by the last request |

## Verification
A lost or stuck pending bit in the sequencer shows up within the request it corrupts. Either a lane's done flag never rises, or the strobe comes too early or never, and `req_cycles` drifts from the busiest-bank count. A wrong choice of service order moves individual done flags to the wrong edge, and the per-clock comparison sees this in the very cycle it happens. A bad write-merge or read-before-write choice corrupts the stored word, which appears in the read data of the same request or at the next read of that word.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

  // sequencer state of the arbiter
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } arb_state_t;

endpackage

// File: rtl/sbank_pick.sv
// Per-bank selection: the lowest pending lane fixes the row served this
// cycle; every pending lane on that row rides along. Among those, the
// highest writing lane supplies the write data.
module sbank_pick #(
  parameter int LANES  = 16,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*ROW_W-1:0]  row_flat,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*DATA_W-1:0] wd_flat,
  output logic [ROW_W-1:0]        sel_row,
  output logic [LANES-1:0]        hit_mask,
  output logic                    wr_en,
  output logic [DATA_W-1:0]       wr_data
);

  int lead;

  always_comb begin
    lead = 0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (req_mask[l]) lead = l;
    end
    sel_row = row_flat[lead*ROW_W +: ROW_W];

    for (int l = 0; l < LANES; l++) begin
      hit_mask[l] = req_mask[l] && (row_flat[l*ROW_W +: ROW_W] == sel_row);
    end

    wr_en   = 1'b0;
    wr_data = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit_mask[l] && lane_we[l]) begin
        wr_en   = 1'b1;
        wr_data = wd_flat[l*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/sbank_store.sv
// One scratchpad bank: single write port, read of the same row.
module sbank_store #(
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[row] <= wdata;
  end

  // read sees the pre-write content of the row in the same cycle
  assign rdata = mem[row];

endmodule

// File: rtl/sbank_arbiter.sv
module sbank_arbiter
  import sbank_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int BANK_BITS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  localparam int BANKS    = 1 << BANK_BITS,
  localparam int ROW_W    = ADDR_W - BANK_BITS,
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_go,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*DATA_W-1:0] lane_wdata,
  output logic                    ready,
  output logic [LANES*DATA_W-1:0] lane_rdata,
  output logic [LANES-1:0]        lane_done,
  output logic                    req_done,
  output logic [CNT_W-1:0]        req_cycles
);

  arb_state_t          state_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES-1:0]    we_q;
  logic [ADDR_W-1:0]   addr_q [LANES];
  logic [DATA_W-1:0]   wd_q   [LANES];
  logic [DATA_W-1:0]   rd_q   [LANES];
  logic [CNT_W-1:0]    cnt_q;

  logic [LANES*ROW_W-1:0]  row_flat;
  logic [LANES*DATA_W-1:0] wd_flat;
  logic [LANES-1:0]        hit     [BANKS];
  logic [DATA_W-1:0]       bank_rd [BANKS];
  logic [LANES-1:0]        served;
  logic [LANES-1:0]        pend_nxt;
  logic                    any_served;

  assign ready = (state_q == ST_IDLE);

  // lane-side flattening
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign row_flat[l*ROW_W +: ROW_W]     = addr_q[l][ADDR_W-1:BANK_BITS];
    assign wd_flat[l*DATA_W +: DATA_W]    = wd_q[l];
    assign lane_rdata[l*DATA_W +: DATA_W] = rd_q[l];
  end

  // one picker and one storage bank per bank index
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANES-1:0]  req_here;
    logic [ROW_W-1:0]  sel_row;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        req_here[l] = pend_q[l] && (addr_q[l][BANK_BITS-1:0] == BANK_BITS'(b));
      end
    end

    sbank_pick #(
      .LANES (LANES),
      .ROW_W (ROW_W),
      .DATA_W(DATA_W)
    ) u_pick (
      .req_mask(req_here),
      .row_flat(row_flat),
      .lane_we (we_q),
      .wd_flat (wd_flat),
      .sel_row (sel_row),
      .hit_mask(hit[b]),
      .wr_en   (wr_en),
      .wr_data (wr_data)
    );

    sbank_store #(
      .ROW_W (ROW_W),
      .DATA_W(DATA_W)
    ) u_store (
      .clk  (clk),
      .wr_en(wr_en),
      .row  (sel_row),
      .wdata(wr_data),
      .rdata(bank_rd[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | hit[b];
    pend_nxt   = pend_q & ~served;
    any_served = |served;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      we_q       <= '0;
      cnt_q      <= '0;
      lane_done  <= '0;
      req_done   <= 1'b0;
      req_cycles <= '0;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l] <= '0;
        wd_q[l]   <= '0;
        rd_q[l]   <= '0;
      end
    end else begin
      req_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_go) begin
            pend_q    <= lane_valid;
            we_q      <= lane_we;
            cnt_q     <= '0;
            lane_done <= '0;
            for (int l = 0; l < LANES; l++) begin
              addr_q[l] <= lane_addr[l*ADDR_W +: ADDR_W];
              wd_q[l]   <= lane_wdata[l*DATA_W +: DATA_W];
            end
            state_q <= ST_SERVE;
          end
        end
        ST_SERVE: begin
          pend_q    <= pend_nxt;
          lane_done <= lane_done | served;
          cnt_q     <= cnt_q + CNT_W'(any_served);
          for (int l = 0; l < LANES; l++) begin
            if (served[l]) rd_q[l] <= bank_rd[addr_q[l][BANK_BITS-1:0]];
          end
          if (pend_nxt == '0) begin
            req_done   <= 1'b1;
            req_cycles <= cnt_q + CNT_W'(any_served);
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbank_arb_chk.sv
module sbank_arb_chk #(
  parameter int LANES = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_go,
  input logic             ready,
  input logic [LANES-1:0] lane_valid,
  input logic [LANES-1:0] lane_done,
  input logic             req_done,
  input logic [CNT_W-1:0] req_cycles
);

  logic [LANES-1:0] vmask_q;

  always_ff @(posedge clk) begin
    if (rst) vmask_q <= '0;
    else if (req_go && ready) vmask_q <= lane_valid;
  end

  // R7: completion strobe lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  // R7: block is idle whenever the strobe is seen
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_done |-> ready);

  // R8: an accepted request makes the block busy
  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_go && ready) |=> !ready);

  // R4: done flags only clear on acceptance
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !(req_go && ready) |=> ((lane_done & $past(lane_done)) == $past(lane_done)));

  // R9: at completion exactly the valid lanes are done
  assert_done_mask_R9: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (lane_done == vmask_q));

  // R3: cycle count never exceeds the lane count
  assert_cycles_bound_R3: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (req_cycles <= CNT_W'(LANES)));

endmodule

bind sbank_arbiter sbank_arb_chk #(
  .LANES(LANES),
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_go    (req_go),
  .ready     (ready),
  .lane_valid(lane_valid),
  .lane_done (lane_done),
  .req_done  (req_done),
  .req_cycles(req_cycles)
);

// File: tb/tb_sbank_arbiter.sv
`timescale 1ns/1ps
module tb_sbank_arbiter;

  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_go;
  logic [15:0]   lane_valid;
  logic [127:0]  lane_addr;
  logic [15:0]   lane_we;
  logic [511:0]  lane_wdata;
  logic          ready;
  logic [511:0]  lane_rdata;
  logic [15:0]   lane_done;
  logic          req_done;
  logic [4:0]    req_cycles;

  always #2.5 clk = ~clk;

  sbank_arbiter dut (
    .clk(clk), .rst(rst), .req_go(req_go), .lane_valid(lane_valid),
    .lane_addr(lane_addr), .lane_we(lane_we), .lane_wdata(lane_wdata),
    .ready(ready), .lane_rdata(lane_rdata), .lane_done(lane_done),
    .req_done(req_done), .req_cycles(req_cycles)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] model [256];
  int          t_a  [NL];
  logic        t_v  [NL];
  logic        t_w  [NL];
  logic [31:0] t_d  [NL];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int leader(input int l);
    for (int m = 0; m < NL; m++)
      if (t_v[m] && t_a[m] == t_a[l]) return m;
    return l;
  endfunction

  // service slot (1-based) of a valid lane
  function automatic int slot(input int l);
    int f, r;
    f = leader(l);
    r = 0;
    for (int m = 0; m < f; m++)
      if (t_v[m] && leader(m) == m && (t_a[m] % 16) == (t_a[l] % 16) && t_a[m] != t_a[l])
        r++;
    return r + 1;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  // issue one request and compare against the reference every clock;
  // poke=1 also drives a stray request while busy (must be ignored)
  task automatic run_req(input string tag, input bit poke);
    int          sl [NL];
    int          c, last;
    logic [31:0] exp_rd [NL];
    c = 0;
    for (int l = 0; l < NL; l++) begin
      sl[l] = t_v[l] ? slot(l) : 0;
      if (sl[l] > c) c = sl[l];
      exp_rd[l] = model[t_a[l]];
    end
    last = (c == 0) ? 1 : c;
    check(ready == 1'b1, "R8", {tag, " ready before go"}, ready, 1);
    for (int l = 0; l < NL; l++) begin
      lane_valid[l]          = t_v[l];
      lane_we[l]             = t_w[l];
      lane_addr[l*8 +: 8]    = 8'(t_a[l]);
      lane_wdata[l*32 +: 32] = t_d[l];
    end
    req_go = 1'b1;
    @(negedge clk);
    if (poke) begin
      for (int l = 0; l < NL; l++) begin
        lane_valid[l]          = 1'b1;
        lane_we[l]             = 1'b1;
        lane_addr[l*8 +: 8]    = 8'(t_a[l]);
        lane_wdata[l*32 +: 32] = 32'hDEAD_0000 + 32'(l);
      end
    end else begin
      req_go = 1'b0;
    end
    check(ready == 1'b0 && lane_done == 16'h0, "R8", {tag, " busy after accept"},
          {ready, lane_done}, 0);
    for (int k = 1; k <= last; k++) begin
      logic [15:0] ed;
      @(negedge clk);
      req_go = 1'b0;
      lane_valid = '0;
      ed = '0;
      for (int l = 0; l < NL; l++) ed[l] = t_v[l] && sl[l] <= k;
      check(lane_done == ed, "R4", {tag, " per-cycle done flags"}, lane_done, ed);
      check(req_done == (k == last), "R7", {tag, " strobe timing"}, req_done, k == last);
    end
    check(req_cycles == 5'(c), "R3", {tag, " cycle count"}, req_cycles, c);
    for (int l = 0; l < NL; l++)
      if (t_v[l] && !t_w[l])
        check(lane_rdata[l*32 +: 32] == exp_rd[l], "R5", {tag, " read data"},
              lane_rdata[l*32 +: 32], exp_rd[l]);
    @(negedge clk);
    check(req_done == 1'b0 && ready == 1'b1, "R7", {tag, " strobe one cycle"},
          {req_done, ready}, 2'b01);
    // model update: ascending lanes, so the highest writer wins (R6)
    for (int l = 0; l < NL; l++)
      if (t_v[l] && t_w[l]) model[t_a[l]] = t_d[l];
  endtask

  task automatic pat(input int base, input int stride, input bit wr);
    for (int l = 0; l < NL; l++) begin
      t_v[l] = 1'b1;
      t_w[l] = wr;
      t_a[l] = (base + l * stride) % 256;
      t_d[l] = rnd();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; req_go = 1'b0; lane_valid = '0; lane_we = '0;
    lane_addr = '0; lane_wdata = '0;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(ready && lane_done == 0 && !req_done && req_cycles == 0, "R10",
          "reset outputs", {ready, lane_done, req_done, req_cycles}, 23'h400000);

    // fill every word: 16 stride-1 writes, conflict-free (R1)
    for (int r = 0; r < 16; r++) begin
      pat(r * 16, 1, 1'b1);
      run_req("R1 fill", 1'b0);
    end
    pat(3, 1, 1'b0);    run_req("R1 stride-1 read", 1'b0);
    pat(77, 0, 1'b0);   run_req("R2 broadcast", 1'b0);
    pat(0, 2, 1'b0);    run_req("R3 stride-2", 1'b0);
    pat(5, 8, 1'b0);    run_req("R3 stride-8", 1'b0);
    pat(9, 16, 1'b0);   run_req("R3 stride-16", 1'b0);

    // four distinct words in bank 0, repeated: grouping and order (R4)
    for (int l = 0; l < NL; l++) begin
      t_v[l] = 1'b1; t_w[l] = 1'b0; t_a[l] = ((l * 3) % 4) * 16;
    end
    run_req("R4 grouped order", 1'b0);

    // all lanes write one word: highest lane wins (R6), then read back
    pat(42, 0, 1'b1);   run_req("R6 write merge", 1'b0);
    pat(42, 0, 1'b0);   run_req("R6 readback", 1'b0);

    // read and write of one word together: read sees old data (R5)
    pat(100, 16, 1'b0);
    t_a[0] = 7; t_a[1] = 7; t_w[1] = 1'b1;
    run_req("R5 read-before-write", 1'b0);
    pat(7, 0, 1'b0);    run_req("R5 readback", 1'b0);

    // invalid lanes, including writers, do nothing (R9)
    pat(200, 1, 1'b1);
    for (int l = 0; l < NL; l += 2) t_v[l] = 1'b0;
    run_req("R9 sparse write", 1'b0);
    pat(200, 1, 1'b0);  run_req("R9 readback", 1'b0);
    for (int l = 0; l < NL; l++) t_v[l] = 1'b0;
    run_req("R7 empty", 1'b0);

    // stray go while busy must not write (R8)
    pat(128, 8, 1'b0);  run_req("R8 busy go", 1'b1);
    pat(128, 1, 1'b0);  run_req("R8 readback", 1'b0);

    // mixed random patterns
    for (int i = 0; i < 40; i++) begin
      for (int l = 0; l < NL; l++) begin
        logic [31:0] x;
        x = rnd();
        t_v[l] = x[0] | x[1];
        t_w[l] = x[2] & x[3];
        t_a[l] = int'(x[11:4]) & ((i % 2 == 0) ? 8'h3F : 8'hFF);
        t_d[l] = rnd();
      end
      run_req("R3 random", 1'b0);
    end

    summary();
    $finish;
  end

endmodule